// File: doc/BRIEF.md
# Transmit Completion Status Register

This block keeps one sticky flag per transmit message buffer of a buffer-oriented frame controller. The transmit engine sends a one-cycle completion pulse for a buffer when its frame has gone out, and the matching flag goes high. Software acknowledges a flag by writing a zero to it. Starting a new transmission on a buffer also drops that buffer's flag. The flags, masked by a per-buffer interrupt enable vector, are merged into a single level interrupt.

The register is accessed over a byte-wide lane bus. Lane 0 carries bits 7..0, which sit at the even address. Lane 1 carries bits 15..8, which sit at the next odd address. A lane-enable vector selects which bytes a write touches. A read-modify-write flag marks the read half of an instruction that reads, alters and writes back. During that read the register returns all ones, so the write-back cannot clear flags that were never meant to be cleared. The transmit engine, the request register and the enable register live elsewhere and feed this block as plain vectors.

Top module: `txc_status_reg`

## Requirements
- R1: While reset is asserted (rst_n low), every flag is 0, a plain read returns 0x0000 and irq is 0.
- R2: A 1 on done_pulse[i] at a rising clock edge makes flag i read as 1 from the next cycle on. Several bits may be pulsed in the same cycle.
- R3: A write (bus_sel=1, bus_we=1) with a 0 in data bit i clears flag i, provided the lane that holds bit i is enabled (bus_lane[0] for bits 7..0, bus_lane[1] for bits 15..8).
- R4: Writing 1 to a flag bit has no effect. This includes writing back 0xFFFF.
- R5: A write leaves every flag in a lane whose bus_lane bit is 0 unchanged, whatever the data bits of that lane hold.
- R6: A 1 on treq_pulse[i] at a clock edge clears flag i.
- R7: When done_pulse[i] coincides with a clear of flag i, the flag ends at 1. The clear may come from a zero write or from treq_pulse[i].
- R8: A read with bus_rmw=1 (bus_sel=1, bus_we=0) returns 0xFFFF on bus_rdata, whatever the flags hold.
- R9: irq is 1 exactly when some flag i and int_en[i] are both 1, in the same cycle, with no register in between. It stays high until every enabled flag is cleared.
- R10: A read with bus_rmw=0 returns the current flags on bus_rdata, bit i for buffer i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Bus access to this register |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_rmw | input | 1 | Access is part of a read-modify-write |
| bus_lane | input | 2 | Byte lane enables, bit 0 = low byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| done_pulse | input | 16 | Per-buffer transmit completion pulses |
| treq_pulse | input | 16 | Per-buffer new transmit request pulses |
| int_en | input | 16 | Per-buffer interrupt enables |
| irq | output | 1 | Combined completion interrupt |

## Verification
Some properties are checked on every cycle:
- a completion pulse always leaves its flag set, and no flag ever rises without a pulse;
- a request pulse clears its flag unless a pulse for the same buffer arrives with it;
- a flag falls only when its lane was written or its request pulsed;
- a read-modify-write read returns all ones;
- irq matches the masked flags.

Only the bench scenarios show the data-dependent outcomes against a reference model:
- zero bits clear and one bits are ignored inside a single write;
- lane isolation holds when the data carries zeros;
- a set beats a clear in the same cycle;
- the read-then-write-back sequence leaves the register untouched.

// File: rtl/txc_pkg.sv
package txc_pkg;
   localparam int LANE_W = 8;

   function automatic int lanes_for(input int nbits);
      return nbits / LANE_W;
   endfunction
endpackage

// File: rtl/txc_lane.sv
module txc_lane #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_hit,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] done,
   input  logic [W-1:0] treq,
   output logic [W-1:0] flags
);
   logic [W-1:0] clr;

   // zero in write data clears; request pulse clears; completion wins
   always_comb clr = treq | (wr_hit ? ~wdata : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr) | done;
   end
endmodule

// File: rtl/txc_irq_tree.sv
module txc_irq_tree #(
   parameter int N        = 16,
   parameter bit IRQ_PIPE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flags,
   input  logic [N-1:0] en,
   output logic         irq
);
   logic hit;
   always_comb hit = |(flags & en);

   generate
      if (IRQ_PIPE) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= hit;
         end
         assign irq = irq_q;
      end else begin : g_comb
         assign irq = hit;
      end
   endgenerate
endmodule

// File: rtl/txc_read_mux.sv
module txc_read_mux #(
   parameter int N = 16
) (
   input  logic         rmw_rd,
   input  logic [N-1:0] flags,
   output logic [N-1:0] rdata
);
   always_comb rdata = rmw_rd ? '1 : flags;
endmodule

// File: rtl/txc_status_reg.sv
module txc_status_reg #(
   parameter int NUM_BUF  = 16,
   parameter bit IRQ_PIPE = 1'b0,
   localparam int NL      = txc_pkg::lanes_for(NUM_BUF),
   localparam int LW      = txc_pkg::LANE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_we,
   input  logic               bus_rmw,
   input  logic [NL-1:0]      bus_lane,
   input  logic [NUM_BUF-1:0] bus_wdata,
   output logic [NUM_BUF-1:0] bus_rdata,
   input  logic [NUM_BUF-1:0] done_pulse,
   input  logic [NUM_BUF-1:0] treq_pulse,
   input  logic [NUM_BUF-1:0] int_en,
   output logic               irq
);
   generate
      if (NUM_BUF % LW != 0 || NUM_BUF < LW) begin : g_bad_width
         $error("NUM_BUF must be a nonzero multiple of the lane width");
      end
   endgenerate

   logic [NUM_BUF-1:0] stat_q;
   logic               wr_acc;
   logic               rmw_rd;

   always_comb begin
      wr_acc = bus_sel & bus_we;
      rmw_rd = bus_sel & ~bus_we & bus_rmw;
   end

   generate
      for (genvar l = 0; l < NL; l++) begin : g_lane
         txc_lane #(.W(LW)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_hit(wr_acc & bus_lane[l]),
            .wdata (bus_wdata[l*LW +: LW]),
            .done  (done_pulse[l*LW +: LW]),
            .treq  (treq_pulse[l*LW +: LW]),
            .flags (stat_q[l*LW +: LW])
         );
      end
   endgenerate

   txc_irq_tree #(.N(NUM_BUF), .IRQ_PIPE(IRQ_PIPE)) u_irq (
      .clk  (clk),
      .rst_n(rst_n),
      .flags(stat_q),
      .en   (int_en),
      .irq  (irq)
   );

   txc_read_mux #(.N(NUM_BUF)) u_rd (
      .rmw_rd(rmw_rd),
      .flags (stat_q),
      .rdata (bus_rdata)
   );
endmodule

// File: rtl/txc_status_chk.sv
module txc_status_chk #(
   parameter int NUM_BUF  = 16,
   parameter bit IRQ_PIPE = 1'b0,
   localparam int NL      = txc_pkg::lanes_for(NUM_BUF),
   localparam int LW      = txc_pkg::LANE_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_we,
   input logic               bus_rmw,
   input logic [NL-1:0]      bus_lane,
   input logic [NUM_BUF-1:0] bus_rdata,
   input logic [NUM_BUF-1:0] done_pulse,
   input logic [NUM_BUF-1:0] treq_pulse,
   input logic [NUM_BUF-1:0] int_en,
   input logic [NUM_BUF-1:0] stat_q,
   input logic               irq
);
   logic [NUM_BUF-1:0] may_clear;
   always_comb begin
      for (int b = 0; b < NUM_BUF; b++)
         may_clear[b] = treq_pulse[b] | (bus_sel & bus_we & bus_lane[b / LW]);
   end

   // R2: a completion pulse always leaves its flag set
   a_r2_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|done_pulse) |=> ((stat_q & $past(done_pulse)) == $past(done_pulse)));

   // R2: no flag rises without a completion pulse
   a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(done_pulse)) == '0));

   // R6, R7: a request pulse clears unless a completion for the same buffer coincides
   a_r6_req_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (|(treq_pulse & ~done_pulse)) |=> ((stat_q & $past(treq_pulse & ~done_pulse)) == '0));

   // R5: a flag only falls when its lane was written or its request pulsed
   a_r5_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~stat_q & $past(stat_q) & ~$past(may_clear)) == '0));

   // R8: read half of a read-modify-write returns all ones
   a_r8_rmw_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_rmw) |-> (bus_rdata == '1));

   generate
      if (!IRQ_PIPE) begin : g_irq_chk
         // R9: interrupt follows masked flags in the same cycle
         a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
            irq == (|(stat_q & int_en)));
      end
   endgenerate
endmodule

bind txc_status_reg txc_status_chk #(.NUM_BUF(NUM_BUF), .IRQ_PIPE(IRQ_PIPE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_rmw   (bus_rmw),
   .bus_lane  (bus_lane),
   .bus_rdata (bus_rdata),
   .done_pulse(done_pulse),
   .treq_pulse(treq_pulse),
   .int_en    (int_en),
   .stat_q    (stat_q),
   .irq       (irq)
);

// File: tb/test_txc_status_reg.sv
module test_txc_status_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0, bus_rmw = 1'b0;
   logic [1:0]  bus_lane = 2'b00;
   logic [15:0] bus_wdata = '0, bus_rdata;
   logic [15:0] done_pulse = '0, treq_pulse = '0, int_en = '0;
   logic        irq;

   always #10 clk = ~clk;

   txc_status_reg i_txc_status_reg (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_rmw(bus_rmw), .bus_lane(bus_lane), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .done_pulse(done_pulse),
      .treq_pulse(treq_pulse), .int_en(int_en), .irq(irq)
   );

   typedef struct {
      logic [15:0] data;
      logic        irq;
      string       tag;
   } exp_t;

   exp_t        exp_q[$];
   int          n_chk = 0, n_err = 0;
   logic [15:0] model = '0;
   bit          done_flag = 0;

   // monitor: pops expected items and compares with live outputs
   initial begin
      forever begin
         wait (exp_q.size() != 0);
         begin
            exp_t it;
            it = exp_q.pop_front();
            n_chk++;
            if (bus_rdata !== it.data || irq !== it.irq) begin
               n_err++;
               $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                        it.tag, bus_rdata, irq, it.data, it.irq);
            end
         end
      end
   end

   // one clock with pulses and an optional write; model updated from requirements
   task automatic cycle(input logic [15:0] dn, input logic [15:0] rq,
                        input logic we, input logic [1:0] ln, input logic [15:0] wd);
      logic [15:0] lmask, clr;
      @(negedge clk);
      done_pulse = dn; treq_pulse = rq;
      bus_sel = we; bus_we = we; bus_lane = ln; bus_wdata = wd;
      @(posedge clk);
      #1;
      lmask = {{8{ln[1]}}, {8{ln[0]}}};
      clr   = rq | (we ? (~wd & lmask) : 16'h0);
      model = (model & ~clr) | dn;
      done_pulse = '0; treq_pulse = '0;
      bus_sel = 0; bus_we = 0; bus_lane = '0; bus_wdata = '0;
   endtask

   // driver: read access, push expected item, wait for monitor
   task automatic check_read(input logic rmw, input string tag);
      exp_t it;
      @(negedge clk);
      bus_sel = 1; bus_we = 0; bus_rmw = rmw;
      #1;
      it.data = rmw ? 16'hFFFF : model;
      it.irq  = |(model & int_en);
      it.tag  = tag;
      exp_q.push_back(it);
      wait (exp_q.size() == 0);
      #1;
      bus_sel = 0; bus_rmw = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      model = '0;
      check_read(0, "R1 reset flags zero");
      rst_n = 1'b1;
      check_read(0, "R1 R10 read after reset");

      cycle(16'h0001, 0, 0, 2'b00, 0);
      check_read(0, "R2 single completion");
      cycle(16'h8420, 0, 0, 2'b00, 0);
      check_read(0, "R2 several completions same cycle");

      int_en = 16'h0002;
      check_read(0, "R9 irq low with no enabled flag");
      int_en = 16'h0001;
      check_read(0, "R9 irq high with enabled flag");

      cycle(0, 0, 1, 2'b01, 16'hFFFE);
      check_read(0, "R3 R4 zero clears bit0, ones ignored");
      check_read(0, "R9 irq drops after enabled flag cleared");

      cycle(16'h00F0, 0, 0, 2'b00, 0);
      cycle(0, 0, 1, 2'b10, 16'h0000);
      check_read(0, "R5 upper-lane write leaves lower lane");
      cycle(16'h0F00, 0, 0, 2'b00, 0);
      cycle(0, 0, 1, 2'b01, 16'h0000);
      check_read(0, "R5 lower-lane write leaves upper lane");

      cycle(0, 16'h0100, 0, 2'b00, 0);
      check_read(0, "R6 request pulse clears flag");

      cycle(16'h0200, 0, 1, 2'b11, 16'h0000);
      check_read(0, "R7 completion beats zero write");
      cycle(16'h0400, 16'h0400, 0, 2'b00, 0);
      check_read(0, "R7 completion beats request pulse");

      check_read(1, "R8 rmw read returns all ones");
      cycle(0, 0, 1, 2'b11, 16'hFFFF);
      check_read(0, "R4 write-back of all ones changes nothing");

      int_en = 16'h0600;
      check_read(0, "R9 irq held with two enabled flags");
      cycle(0, 0, 1, 2'b10, 16'hFDFF);
      check_read(0, "R9 irq held while one enabled flag remains");
      cycle(0, 0, 1, 2'b10, 16'hFBFF);
      check_read(0, "R9 irq released after all enabled flags cleared");

      cycle(16'hFFFF, 0, 0, 2'b00, 0);
      check_read(0, "R2 all flags set");
      @(negedge clk);
      rst_n = 0;
      model = '0;
      check_read(0, "R1 reset clears all flags");
      rst_n = 1;

      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule